// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter with Loadable Tables

This block computes a linear-phase FIR filter output without any multiplier. Each accepted input sample is pushed into a tap delay line, and every pair of taps that share a coefficient is summed word-parallel into one pre-added term (the centre tap of an odd-length filter stands alone). The terms are then processed one bit position at a time, most significant first: the bit of every term at that position forms the address into a set of small lookup tables of at most four inputs each, whose outputs meet in a registered adder tree and are folded into a doubling accumulator.

The table contents are not fixed at build time. A write port loads them, so the coefficient set can be swapped while the filter runs. Each entry holds the sum of the coefficients selected by the set bits of its address; the caller computes these entries from the wanted coefficients. Shorter filters or narrower coefficients are obtained by loading zero for the unused coefficients.

A sample is taken only while `in_ready` is high. One serial pass lasts `BX+1` cycles, after which the next sample may enter; the result appears on `out_result` with a one-cycle `out_valid` pulse a fixed number of cycles after acceptance.

Top module: `dafir_filter`

## Requirements
- R1: After reset `out_valid` is 0, `out_result` is 0, `in_ready` is 1 and every table entry is zero, so the first outputs are zero until tables are loaded.
- R2: For an accepted sample, the result equals the sum over n = 0..N_TAPS-1 of c[n]·x[n], where x[0] is the sample just accepted, x[n] the one accepted n samples earlier (zero before any), all values two's complement, and c[n] = c[N_TAPS-1-n].
- R3: Table t (0-based, `cfg_tbl`) input i serves pair term j = 4t+i, where term j combines taps j and N_TAPS-1-j; entry a (`cfg_addr`) must hold the sum of c[j] over the set bits i of a. The last table has ceil(N_TAPS/2) mod 4 inputs when that is non-zero, and a write whose address has a set bit at or above that input count changes nothing.
- R4: Extreme inputs (-2^(BX-1), 2^(BX-1)-1) with extreme coefficients (-2^(BC-1)) give the exact result with no wrap.
- R5: After a sample is accepted `in_ready` stays low for exactly BX+1 cycles and then returns high.
- R6: A sample offered while `in_ready` is low is ignored: it does not enter the delay line and does not alter any later result.
- R7: `out_valid` is a single-cycle pulse that rises BX+2+ceil(log2(number of tables)) clock edges after the accepting edge.
- R8: Tables rewritten between passes take effect for the next accepted sample, while the delay line keeps its history; zeroed outer coefficients yield a shorter filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_sample | input | BX | Input sample, two's complement |
| in_ready | output | 1 | High when a sample can be accepted |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_tbl | input | max(1, ceil(log2(NT))) | Index of the table being written |
| cfg_addr | input | 4 | Entry address inside the table |
| cfg_data | input | BC+2 | Entry value, two's complement |
| out_valid | output | 1 | One-cycle pulse: result is final |
| out_result | output | BX+BC+ceil(log2(ceil(N_TAPS/2)))+2 | Filter output, two's complement |

## Verification
A wrong term bit, table entry or accumulator step corrupts the very next result word, which shows up on the first `out_valid` pulse after the faulty pass, roughly a dozen cycles after acceptance. A delay-line fault that lets a busy-time sample in only becomes visible one sample later, since it shifts the history seen by the following output; the bench therefore checks the output that follows each ignored offer. Sequencing faults appear at once as a shifted or stretched `out_valid` pulse or a wrong `in_ready` window, which the bench counts edge by edge.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
    // inputs per partial lookup table
    localparam int LUT_IN = 4;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/dafir_taps.sv
module dafir_taps #(
    parameter int N_TAPS = 11,
    parameter int BX     = 8,
    parameter int M      = 6,
    parameter int TW     = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          shift_en,
    input  logic [BX-1:0] sample,
    output logic [M-1:0]  msb_bits
);
    logic [N_TAPS-1:0][BX-1:0] dl_d, dl_q;
    logic [M-1:0][TW-1:0]      tr_d, tr_q;

    always_comb begin
        dl_d = dl_q;
        tr_d = tr_q;
        if (accept) begin
            dl_d[0] = sample;
            for (int i = 1; i < N_TAPS; i++) begin
                dl_d[i] = dl_q[i-1];
            end
            // word-parallel pre-add of mirrored taps; centre tap alone
            for (int j = 0; j < M; j++) begin
                tr_d[j] = {dl_d[j][BX-1], dl_d[j]}
                        + ((j == N_TAPS-1-j) ? '0
                           : {dl_d[N_TAPS-1-j][BX-1], dl_d[N_TAPS-1-j]});
            end
        end else if (shift_en) begin
            for (int j = 0; j < M; j++) begin
                tr_d[j] = {tr_q[j][TW-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q <= '0;
            tr_q <= '0;
        end else begin
            dl_q <= dl_d;
            tr_q <= tr_d;
        end
    end

    always_comb begin
        for (int j = 0; j < M; j++) begin
            msb_bits[j] = tr_q[j][TW-1];
        end
    end

    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(dl_q)); // R6
endmodule

// File: rtl/dafir_ptable.sv
module dafir_ptable #(
    parameter int NIN = 4,
    parameter int LIN = 4,
    parameter int PW  = 10,
    parameter int TBW = 1,
    parameter int IDX = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [TBW-1:0] cfg_tbl,
    input  logic [LIN-1:0] cfg_addr,
    input  logic [PW-1:0]  cfg_data,
    input  logic [NIN-1:0] rd_addr,
    output logic [PW-1:0]  rd_data
);
    localparam int DEPTH = 1 << NIN;

    logic [DEPTH-1:0][PW-1:0] mem_d, mem_q;
    logic [PW-1:0]            rd_d, rd_q;
    logic                     in_rng;

    generate
        if (NIN < LIN) begin : g_narrow
            assign in_rng = (cfg_addr[LIN-1:NIN] == '0);
        end else begin : g_full
            assign in_rng = 1'b1;
        end
    endgenerate

    always_comb begin
        mem_d = mem_q;
        if (cfg_we && (cfg_tbl == TBW'(IDX)) && in_rng) begin
            mem_d[cfg_addr[NIN-1:0]] = cfg_data;
        end
        rd_d = mem_q[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            rd_q  <= '0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    assign rd_data = rd_q;

    AST_TABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(mem_q)); // R3
endmodule

// File: rtl/dafir_addtree.sv
module dafir_addtree #(
    parameter int NT = 2,
    parameter int PW = 10,
    parameter int TD = 1,
    parameter int SW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] leaf [NT],
    input  logic          vin,
    input  logic          fin,
    input  logic          lin,
    output logic [SW-1:0] root,
    output logic          vout,
    output logic          fout,
    output logic          lout
);
    generate
        if (TD == 0) begin : g_pass
            assign root = leaf[0];
            assign vout = vin;
            assign fout = fin;
            assign lout = lin;
        end else begin : g_tree
            localparam int P = 1 << TD;
            logic [SW-1:0]       leaf_w [P];
            logic [SW-1:0]       node_d [1:P-1];
            logic [SW-1:0]       node_q [1:P-1];
            logic [TD-1:0][2:0]  flag_q;

            for (genvar gi = 0; gi < P; gi++) begin : g_leaf
                if (gi < NT) begin : g_used
                    assign leaf_w[gi] = {{TD{leaf[gi][PW-1]}}, leaf[gi]};
                end else begin : g_pad
                    assign leaf_w[gi] = '0;
                end
            end

            for (genvar gn = 1; gn < P; gn++) begin : g_node
                if (2*gn >= P) begin : g_low
                    assign node_d[gn] = leaf_w[2*gn-P] + leaf_w[2*gn+1-P];
                end else begin : g_high
                    assign node_d[gn] = node_q[2*gn] + node_q[2*gn+1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 1; i < P; i++) node_q[i] <= '0;
                    flag_q <= '0;
                end else begin
                    for (int i = 1; i < P; i++) node_q[i] <= node_d[i];
                    flag_q[0] <= {vin, fin, lin};
                    for (int k = 1; k < TD; k++) flag_q[k] <= flag_q[k-1];
                end
            end

            assign root = node_q[1];
            assign vout = flag_q[TD-1][2];
            assign fout = flag_q[TD-1][1];
            assign lout = flag_q[TD-1][0];
        end
    endgenerate
endmodule

// File: rtl/dafir_filter.sv
module dafir_filter
    import dafir_pkg::*;
#(
    parameter  int N_TAPS = 11,
    parameter  int BX     = 8,
    parameter  int BC     = 8,
    localparam int TW     = BX + 1,
    localparam int M      = (N_TAPS + 1) / 2,
    localparam int NT     = (M + LUT_IN - 1) / LUT_IN,
    localparam int REM    = M % LUT_IN,
    localparam int PW     = BC + $clog2(LUT_IN),
    localparam int TD     = $clog2(NT),
    localparam int SW     = PW + TD,
    localparam int OW     = BX + BC + $clog2(M) + 2,
    localparam int TBW    = (NT > 1) ? $clog2(NT) : 1,
    localparam int CW     = $clog2(TW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BX-1:0]     in_sample,
    output logic              in_ready,
    input  logic              cfg_we,
    input  logic [TBW-1:0]    cfg_tbl,
    input  logic [LUT_IN-1:0] cfg_addr,
    input  logic [PW-1:0]     cfg_data,
    output logic              out_valid,
    output logic [OW-1:0]     out_result
);
    typedef struct packed {
        seq_state_e     state;
        logic [CW-1:0]  bcnt;
        logic           pv;
        logic           pf;
        logic           pl;
        logic [OW-1:0]  acc;
        logic [OW-1:0]  res;
        logic           ovld;
    } ctrl_t;

    ctrl_t          c_d, c_q;
    logic           accept, shift_en;
    logic [M-1:0]   msb_bits;
    logic [PW-1:0]  leaf [NT];
    logic [SW-1:0]  sum;
    logic           sv, sf, sl;
    logic [OW-1:0]  sum_x, acc_nx;

    dafir_taps #(.N_TAPS(N_TAPS), .BX(BX), .M(M), .TW(TW)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .shift_en (shift_en),
        .sample   (in_sample),
        .msb_bits (msb_bits)
    );

    generate
        for (genvar t = 0; t < NT; t++) begin : g_tbl
            localparam int NIN = (t == NT-1 && REM != 0) ? REM : LUT_IN;
            dafir_ptable #(.NIN(NIN), .LIN(LUT_IN), .PW(PW), .TBW(TBW), .IDX(t)) u_tbl (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_we   (cfg_we),
                .cfg_tbl  (cfg_tbl),
                .cfg_addr (cfg_addr),
                .cfg_data (cfg_data),
                .rd_addr  (msb_bits[t*LUT_IN +: NIN]),
                .rd_data  (leaf[t])
            );
        end
    endgenerate

    dafir_addtree #(.NT(NT), .PW(PW), .TD(TD), .SW(SW)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .leaf  (leaf),
        .vin   (c_q.pv),
        .fin   (c_q.pf),
        .lin   (c_q.pl),
        .root  (sum),
        .vout  (sv),
        .fout  (sf),
        .lout  (sl)
    );

    always_comb begin
        c_d      = c_q;
        accept   = in_valid && (c_q.state == ST_IDLE);
        shift_en = (c_q.state == ST_SHIFT);

        // bit-slice flags travelling with the table read
        c_d.pv = shift_en;
        c_d.pf = shift_en && (c_q.bcnt == '0);
        c_d.pl = shift_en && (c_q.bcnt == CW'(TW-1));

        case (c_q.state)
            ST_IDLE: begin
                if (accept) begin
                    c_d.state = ST_SHIFT;
                    c_d.bcnt  = '0;
                end
            end
            default: begin
                c_d.bcnt = c_q.bcnt + 1'b1;
                if (c_q.bcnt == CW'(TW-1)) c_d.state = ST_IDLE;
            end
        endcase

        // MSB-first: sign slice negated, then double-and-add
        sum_x  = {{(OW-SW){sum[SW-1]}}, sum};
        acc_nx = sf ? (~sum_x + 1'b1) : ({c_q.acc[OW-2:0], 1'b0} + sum_x);
        c_d.ovld = 1'b0;
        if (sv) begin
            c_d.acc = acc_nx;
            if (sl) begin
                c_d.res  = acc_nx;
                c_d.ovld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign in_ready   = (c_q.state == ST_IDLE);
    assign out_valid  = c_q.ovld;
    assign out_result = c_q.res;

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R7
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> (out_valid || $stable(out_result))); // R2
endmodule

// File: tb/dafir_filter_tb.sv
`timescale 1ns/1ps
module dafir_filter_tb;
    localparam int N_TAPS = 11;
    localparam int BX     = 8;
    localparam int BC     = 8;
    localparam int TW     = BX + 1;
    localparam int M      = (N_TAPS + 1) / 2;
    localparam int NT     = (M + 3) / 4;
    localparam int REM    = M % 4;
    localparam int PW     = BC + 2;
    localparam int TD     = $clog2(NT);
    localparam int OW     = BX + BC + $clog2(M) + 2;
    localparam int TBW    = (NT > 1) ? $clog2(NT) : 1;
    localparam int LAT    = TW + TD + 1;
    localparam int STIM_LEN = 20;

    // stimulus vectors; expected results come from the MAC model below
    localparam int STIM [STIM_LEN] = '{5, -3, 100, -128, 127, 0, 1, -1, 64, -77,
                                       33, -128, -128, 127, 127, 12, -90, 45, 2, -60};
    localparam int COEF_A [M] = '{2, -5, 11, -24, 70, 127};
    localparam int COEF_B [M] = '{0, 0, 9, -17, 40, -128};
    localparam int COEF_C [M] = '{-128, -128, -128, -128, -128, -128};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [BX-1:0]     in_sample;
    logic              in_ready;
    logic              cfg_we;
    logic [TBW-1:0]    cfg_tbl;
    logic [3:0]        cfg_addr;
    logic [PW-1:0]     cfg_data;
    logic              out_valid;
    logic [OW-1:0]     out_result;

    int checks = 0;
    int fails  = 0;
    int ch   [M];
    int hist [N_TAPS];

    always #2 clk = ~clk;

    dafir_filter #(.N_TAPS(N_TAPS), .BX(BX), .BC(BC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_ready   (in_ready),
        .cfg_we     (cfg_we),
        .cfg_tbl    (cfg_tbl),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_out();
        int y = 0;
        for (int n = 0; n < N_TAPS; n++) begin
            int j = (n < N_TAPS-1-n) ? n : N_TAPS-1-n;
            y += ch[j] * hist[n];
        end
        return y;
    endfunction

    task automatic cfg_write(input int t, input int a, input int d);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_tbl  = t[TBW-1:0];
        cfg_addr = a[3:0];
        cfg_data = d[PW-1:0];
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic load_coefs(input int sel);
        for (int j = 0; j < M; j++)
            ch[j] = (sel == 0) ? COEF_A[j] : (sel == 1) ? COEF_B[j] : COEF_C[j];
        for (int t = 0; t < NT; t++) begin
            int nin = (t == NT-1 && REM != 0) ? REM : 4;
            for (int a = 0; a < (1 << nin); a++) begin
                int e = 0;
                for (int i = 0; i < nin; i++)
                    if (a[i]) e += ch[4*t + i];
                cfg_write(t, a, e);
            end
        end
    endtask

    task automatic send(input int s, input bit junk, input string req);
        int cnt = 0;
        int exp;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_sample = s[BX-1:0];
        @(negedge clk);
        check(in_ready == 1'b0, "R5", in_ready, 0);
        for (int n = N_TAPS-1; n > 0; n--) hist[n] = hist[n-1];
        hist[0] = s;
        exp = ref_out();
        if (junk) in_sample = 8'h5A;
        else      in_valid  = 1'b0;
        while (!out_valid && cnt < LAT + 20) begin
            @(negedge clk);
            cnt++;
            if (junk && cnt == 4) in_valid = 1'b0;
            if (cnt == TW-1) check(in_ready == 1'b0, "R5", in_ready, 0);
            if (cnt == TW)   check(in_ready == 1'b1, "R5", in_ready, 1);
        end
        check(cnt == LAT, "R7", cnt, LAT);
        check(int'($signed(out_result)) == exp, req, int'($signed(out_result)), exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R7", out_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
        cfg_we = 1'b0; cfg_tbl = '0; cfg_addr = '0; cfg_data = '0;
        for (int j = 0; j < M; j++) ch[j] = 0;
        for (int n = 0; n < N_TAPS; n++) hist[n] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_result == '0, "R1", out_result, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);
        rst_n = 1'b1;
        send(37, 1'b0, "R1");          // tables empty after reset

        load_coefs(0);
        for (int i = 0; i < STIM_LEN; i++) send(STIM[i], 1'b0, "R2");

        // R6: offer junk while busy, the following output proves it was dropped
        send(11, 1'b1, "R6");
        send(-20, 1'b0, "R6");

        // R3: out-of-range address on the narrow last table must change nothing
        cfg_write(NT-1, (1 << REM) + 1, 300);
        send(7, 1'b0, "R3");
        send(-99, 1'b0, "R3");

        // R8: swap to a shorter filter at run time
        load_coefs(1);
        for (int i = 0; i < 6; i++) send(STIM[i+4], 1'b0, "R8");

        // R4: extreme values
        load_coefs(2);
        for (int i = 0; i < N_TAPS; i++) send(-128, 1'b0, "R4");
        for (int i = 0; i < N_TAPS; i++) send(127, 1'b0, "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule